// File: doc/BRIEF.md
# Audio Mute and Tri-State Port Controller

This block sits behind the register file of a television stereo/dual-language sound processor. It combines the power-on reset, an external mute pin, the programmed switch and port-control register values and the raw result of the pilot identification logic. From these it produces three things: one audio mute enable, the gated stereo and dual-sound flags seen by the status path, and a drive value with an output enable for each of two general-purpose pads.

There are two kinds of mute. A full mute comes from reset or from the mute pin. It silences the audio and also forces the identification result to mono. A sound mute is a switch register value of zero. It silences only the audio, and the identification flags stay live. After reset the audio stays silenced until software writes a nonzero switch value. The pads stay driven low until the port-control register is first written.

Top module: `mute_port_ctrl`

## Requirements
- R1: While `por` is high, `audio_mute` is 1, `stereo_o` and `dual_o` are 0, and both pads are driven low (`port_oe`=11, `port_drv`=00). Any state kept from before is discarded.
- R2: After `por` falls, `audio_mute` stays 1 until a cycle with `sw_wr`=1 and `sw_reg`≠0x00. The release is visible from the cycle after that write. A write of 0x00 does not release it.
- R3: While `sw_reg`=0x00, `audio_mute` is 1. If no full mute is active, `stereo_o` and `dual_o` still follow the identification inputs.
- R4: While the synchronized mute pin is active, `audio_mute` is 1 and `stereo_o`=`dual_o`=0.
- R5: Bit 4 of `ctl_reg` sets the pin polarity. With 0 the pin is active when low. With 1 it is active when high.
- R6: After reset both pads stay driven low (`port_oe`=1, `port_drv`=0) until the first cycle with `ctl_wr`=1. From the cycle after that write the pads follow `ctl_reg`.
- R7: Pad 0 is decoded from `ctl_reg[1:0]` and pad 1 from `ctl_reg[3:2]`. Code 00 gives oe=1 and drv=0. Code 01 gives oe=1 and drv=1. Codes 10 and 11 give oe=0 and drv=0.
- R8: `{id_stereo,id_dual}`: 00 is mono, 01 is dual sound and 10 is stereo, and each passes through to `{stereo_o,dual_o}`. 11 is invalid and is reported as mono (00).
- R9: `mute_pin` passes through two flops before the polarity compare. A pin change that is sampled at edge k takes effect at the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| mute_pin | input | 1 | External mute pin, asynchronous |
| sw_reg | input | 8 | Current switch register value |
| ctl_reg | input | 5 | Port-control register bits 4:0 (polarity, pad 1 code, pad 0 code) |
| sw_wr | input | 1 | Write strobe for the switch register |
| ctl_wr | input | 1 | Write strobe for the port-control register |
| id_stereo | input | 1 | Raw stereo identification flag |
| id_dual | input | 1 | Raw dual-sound identification flag |
| audio_mute | output | 1 | Audio mute enable |
| stereo_o | output | 1 | Gated stereo flag |
| dual_o | output | 1 | Gated dual-sound flag |
| port_drv | output | 2 | Drive value per pad |
| port_oe | output | 2 | Output enable per pad |

## Verification
The assertions check the following on every cycle:
- the reset output values;
- that the hold mute persists until a nonzero switch write;
- that a pin mute or an invalid flag pair gives mono;
- that a sound mute silences the audio;
- the two-edge delay of the pin synchronizer;
- the pad codes once the pads are enabled.

Other behaviour is shown only by the bench's scenarios:
- that a zero write leaves the audio muted;
- the switch of polarity under a live pin;
- that the pads ignore a register value that was never strobed;
- that a second reset in mid-operation discards the earlier write history.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  typedef struct packed {
    logic drv;
    logic oe;
  } pad_t;

  // R7: 00 low, 01 high, 1x released; R6: forced low until enabled
  function automatic pad_t pad_decode(input logic [1:0] code, input logic enabled);
    pad_t p;
    if (!enabled) begin
      p.drv = 1'b0;
      p.oe  = 1'b1;
    end else if (code[1]) begin
      p.drv = 1'b0;
      p.oe  = 1'b0;
    end else begin
      p.drv = code[0];
      p.oe  = 1'b1;
    end
    return p;
  endfunction

  // R8: invalid pair and forced mono both give 00; result is {stereo,dual}
  function automatic logic [1:0] ident_gate(input logic st, input logic du, input logic force_mono);
    if (force_mono || (st && du)) return 2'b00;
    return {st, du};
  endfunction

  // R5: pin is active when its level equals the polarity bit
  function automatic logic pin_active(input logic level, input logic pol);
    return level == pol;
  endfunction

endpackage

// File: rtl/mpc_pin_sync.sv
module mpc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic pin_raw,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge por) begin
    if (por) chain <= '0;
    else     chain <= {chain[STAGES-2:0], pin_raw};
  end

  assign pin_sync = chain[STAGES-1];

  // cycles since reset, saturating at STAGES, for the delay check
  localparam int CW = $clog2(STAGES + 1);
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk or posedge por) begin
    if (por) since_rst <= '0;
    else if (since_rst != CW'(STAGES)) since_rst <= since_rst + 1'b1;
  end

  a_r9_two_stage_delay: assert property (@(posedge clk) disable iff (por)
    (since_rst == CW'(STAGES)) |-> (pin_sync == $past(pin_raw, STAGES)))
    else $error("R9 synchronizer delay");

endmodule

// File: rtl/mpc_mute_seq.sv
module mpc_mute_seq (
  input  logic clk,
  input  logic por,
  input  logic sw_wr,
  input  logic sw_nonzero,
  input  logic ctl_wr,
  output logic hold_mute,
  output logic ctl_seen
);
  logic release_ev;
  assign release_ev = sw_wr && sw_nonzero;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      hold_mute <= 1'b1;
      ctl_seen  <= 1'b0;
    end else begin
      if (release_ev) hold_mute <= 1'b0;
      if (ctl_wr)     ctl_seen  <= 1'b1;
    end
  end

  a_r2_hold_until_write: assert property (@(posedge clk) disable iff (por)
    (hold_mute && !release_ev) |=> hold_mute)
    else $error("R2 hold mute dropped without a nonzero write");

  a_r2_release_on_write: assert property (@(posedge clk) disable iff (por)
    release_ev |=> !hold_mute)
    else $error("R2 hold mute not released");

  a_r6_enable_after_write: assert property (@(posedge clk) disable iff (por)
    (!ctl_seen && !ctl_wr) |=> !ctl_seen)
    else $error("R6 pads enabled without a write");

endmodule

// File: rtl/mpc_pad_drv.sv
module mpc_pad_drv
  import mpc_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              enabled,
  input  logic [CODE_W-1:0] code,
  output logic              drv,
  output logic              oe
);
  pad_t p;
  always_comb p = pad_decode(code, enabled);
  assign drv = p.drv;
  assign oe  = p.oe;

  a_r7_high_code: assert property (@(posedge clk) disable iff (por)
    (enabled && code == 2'b01) |-> (oe && drv))
    else $error("R7 code 01 not driven high");

  a_r7_release_code: assert property (@(posedge clk) disable iff (por)
    (enabled && code[1]) |-> !oe)
    else $error("R7 code 1x not released");

  a_r6_low_before_write: assert property (@(posedge clk) disable iff (por)
    !enabled |-> (oe && !drv))
    else $error("R6 pad not held low");

endmodule

// File: rtl/mute_port_ctrl.sv
module mute_port_ctrl
  import mpc_pkg::*;
#(
  parameter int SW_W        = 8,
  parameter int NUM_PADS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            por,
  input  logic                            mute_pin,
  input  logic [SW_W-1:0]                 sw_reg,
  input  logic [NUM_PADS*2:0]             ctl_reg,
  input  logic                            sw_wr,
  input  logic                            ctl_wr,
  input  logic                            id_stereo,
  input  logic                            id_dual,
  output logic                            audio_mute,
  output logic                            stereo_o,
  output logic                            dual_o,
  output logic [NUM_PADS-1:0]             port_drv,
  output logic [NUM_PADS-1:0]             port_oe
);
  localparam int CODE_W  = 2;
  localparam int POL_BIT = NUM_PADS * CODE_W;

  // named internal events for the checks
  logic pin_sync, pin_mute, sound_mute, full_mute, hold_mute, ctl_seen;
  logic [1:0] id_gated;

  mpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por(por), .pin_raw(mute_pin), .pin_sync(pin_sync)
  );

  mpc_mute_seq u_seq (
    .clk(clk), .por(por), .sw_wr(sw_wr), .sw_nonzero(|sw_reg),
    .ctl_wr(ctl_wr), .hold_mute(hold_mute), .ctl_seen(ctl_seen)
  );

  assign pin_mute   = pin_active(pin_sync, ctl_reg[POL_BIT]);
  assign sound_mute = (sw_reg == '0);
  assign full_mute  = por || pin_mute;
  assign audio_mute = full_mute || hold_mute || sound_mute;

  always_comb id_gated = ident_gate(id_stereo, id_dual, full_mute);
  assign stereo_o = id_gated[1];
  assign dual_o   = id_gated[0];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    mpc_pad_drv #(.CODE_W(CODE_W)) u_pad (
      .clk(clk), .por(por), .enabled(ctl_seen && !por),
      .code(ctl_reg[i*CODE_W +: CODE_W]),
      .drv(port_drv[i]), .oe(port_oe[i])
    );
  end

  a_r1_reset_outputs: assert property (@(posedge clk)
    por |-> (audio_mute && !stereo_o && !dual_o && (&port_oe) && !(|port_drv)))
    else $error("R1 reset outputs");

  a_r4_pin_forces_mono: assert property (@(posedge clk) disable iff (por)
    pin_mute |-> (audio_mute && !stereo_o && !dual_o))
    else $error("R4 pin mute");

  a_r3_sound_mute: assert property (@(posedge clk) disable iff (por)
    (sw_reg == '0) |-> audio_mute)
    else $error("R3 sound mute");

  a_r8_invalid_mono: assert property (@(posedge clk) disable iff (por)
    (id_stereo && id_dual) |-> (!stereo_o && !dual_o))
    else $error("R8 invalid pair");

endmodule

// File: tb/tb_mute_port_ctrl.sv
module tb_mute_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por, mute_pin, sw_wr, ctl_wr, id_stereo, id_dual;
  logic [7:0] sw_reg;
  logic [4:0] ctl_reg;
  logic audio_mute, stereo_o, dual_o;
  logic [1:0] port_drv, port_oe;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  mute_port_ctrl dut (
    .clk(clk), .por(por), .mute_pin(mute_pin), .sw_reg(sw_reg), .ctl_reg(ctl_reg),
    .sw_wr(sw_wr), .ctl_wr(ctl_wr), .id_stereo(id_stereo), .id_dual(id_dual),
    .audio_mute(audio_mute), .stereo_o(stereo_o), .dual_o(dual_o),
    .port_drv(port_drv), .port_oe(port_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit m_hold = 1, m_seen = 0;
  bit pin_hist[$];

  always @(posedge clk) begin
    if (por) begin
      m_hold = 1; m_seen = 0; pin_hist.delete();
    end else begin
      pin_hist.push_back(mute_pin);
      if (pin_hist.size() > 4) void'(pin_hist.pop_front());
      if (sw_wr && sw_reg != 8'h00) m_hold = 0;
      if (ctl_wr) m_seen = 1;
    end
  end

  task automatic check1(string what, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit synced, pinm, full, e_mute;
      bit [1:0] e_id, e_oe, e_drv;
      synced = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 1'b0;
      pinm   = !por && (synced == ctl_reg[4]);
      full   = por || pinm;
      e_mute = full || m_hold || (sw_reg == 8'h00);
      e_id   = (full || (id_stereo && id_dual)) ? 2'b00 : {id_stereo, id_dual};
      for (int i = 0; i < 2; i++) begin
        bit [1:0] c;
        c = ctl_reg[2*i +: 2];
        if (por || !m_seen) begin e_oe[i] = 1; e_drv[i] = 0; end
        else if (c[1])      begin e_oe[i] = 0; e_drv[i] = 0; end
        else                begin e_oe[i] = 1; e_drv[i] = c[0]; end
      end
      check1("mute", {3'b0, audio_mute}, {3'b0, e_mute});
      check1("ident", {2'b0, stereo_o, dual_o}, {2'b0, e_id});
      check1("pads", {port_oe, port_drv}, {e_oe, e_drv});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sw(logic [7:0] v);
    sw_reg = v; sw_wr = 1; step(1); sw_wr = 0;
  endtask

  task automatic wr_ctl(logic [4:0] v);
    ctl_reg = v; ctl_wr = 1; step(1); ctl_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    por = 1; mute_pin = 1; sw_reg = 8'h00; ctl_reg = 5'h0F;
    sw_wr = 0; ctl_wr = 0; id_stereo = 1; id_dual = 0;
    cur_req = "R1"; step(3);
    por = 0;
    cur_req = "R2"; step(4);               // hold mute, ident live
    wr_sw(8'h00); step(2);                 // zero write keeps mute
    sw_reg = 8'h2A; step(2);               // value change without strobe
    wr_sw(8'h2A); step(2);                 // released
    cur_req = "R8";
    id_stereo = 0; id_dual = 0; step(1);
    id_stereo = 0; id_dual = 1; step(1);
    id_stereo = 1; id_dual = 0; step(1);
    id_stereo = 1; id_dual = 1; step(2);
    id_stereo = 0; id_dual = 1;
    cur_req = "R3"; sw_reg = 8'h00; step(3); sw_reg = 8'h7E; step(2);
    cur_req = "R9"; mute_pin = 0; step(1); step(1); step(2);
    cur_req = "R4"; id_stereo = 1; id_dual = 0; step(2); mute_pin = 1; step(3);
    cur_req = "R5"; ctl_reg = 5'h1F; step(2); mute_pin = 0; step(3); mute_pin = 1; step(3);
    ctl_reg = 5'h0F; step(1);
    cur_req = "R6"; ctl_reg = 5'h05; step(3);   // register value, no strobe
    cur_req = "R7";
    wr_ctl(5'h04); step(2);
    wr_ctl(5'h09); step(1);
    ctl_reg = 5'h0D; step(2);
    ctl_reg = 5'h03; step(1);
    ctl_reg = 5'h00; step(1);
    cur_req = "R1"; por = 1; step(2); por = 0;
    cur_req = "R6"; ctl_reg = 5'h05; sw_reg = 8'h10; step(4);
    wr_ctl(5'h05); step(2);
    cur_req = "R2"; wr_sw(8'h10); step(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule